// File: doc/BRIEF.md
# External memory strobe pulse timer

This block drives the active-low strobes of one static-memory access. A read drives chip select and read strobe low. A write drives chip select and write strobe low. Each strobe is low for its own number of clock cycles. The numbers come from a small bank of timing registers, one register for each of four chip selects.

Each register holds four 7-bit pulse codes. A code is non-linear: its top bit is worth 256 cycles and its low six bits add their plain value. A code that comes to zero still gives one cycle.

An access starts with a one-cycle request that names the chip select, the direction, a page-mode flag and a same-page flag. The block copies the decoded lengths into two down-counters, so later register writes do not change a pulse already running. It raises a one-cycle done once both strobes are high again.

The timing registers sit behind a plain write port and a combinational read port. A write-protect input blocks writes to them.

Top module: `strobe_pulse_timer`

## Requirements
- R1: A 7-bit code c gives a length of 256*c[6] + c[5:0] clock cycles. A code that gives 0 (c = 0) is used as 1 cycle.
- R2: There are four timing registers, for chip select n = 0..3, at byte address 4 + 4*n. Each resets to 0x01010101. The fields sit at these bits:
  - chip-select length for reads: 30:24
  - read-strobe length: 22:16
  - chip-select length for writes: 14:8
  - write-strobe length: 6:0
- R3: While `wp_en` is 1, writes to the timing registers have no effect. Reads always work.
- R4: For a standard read (`start_wr`=0, `start_page`=0), `cs_n` is low for the chip-select read length and `rd_n` for the read-strobe length. Both go low in the first cycle after the edge that accepts `start`.
- R5: For a write (`start_wr`=1), `cs_n` is low for the chip-select write length and `wr_n` for the write-strobe length. `rd_n` stays high. `start_page` has no effect on a write. During a read, `wr_n` stays high.
- R6: For a page-mode read (`start_wr`=0, `start_page`=1):
  - With `start_same_page`=0 (first access of a page), `cs_n` and `rd_n` are both low for the chip-select read length.
  - With `start_same_page`=1 (later access in the page), both are low for the read-strobe length.
- R7: `busy` is high in exactly the cycles in which a strobe is low. `done` is high for exactly one cycle, the cycle after the longer strobe rises.
- R8: A `start` while `busy` is high is ignored. The running pulse keeps its lengths and no second pulse follows.
- R9: The lengths are taken from the registers at the accepting edge. A register write during a pulse does not change that pulse.
- R10: Bits 31, 23, 15 and 7 of a timing register read as 0. Any address other than 4, 8, 12 or 16 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Byte address for register read and write |
| cfg_wdata | input | 32 | Register write data |
| wp_en | input | 1 | Write-protect enable; blocks register writes when 1 |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| start | input | 1 | Access request, one cycle |
| start_cs | input | 2 | Chip-select index of the access |
| start_wr | input | 1 | 1 = write access, 0 = read access |
| start_page | input | 1 | Page-mode read |
| start_same_page | input | 1 | Access is a later access in the current page |
| cs_n | output | 1 | Chip-select strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| busy | output | 1 | A pulse is in progress |
| done | output | 1 | One-cycle end-of-pulse indication |

## Verification
Two cases are hard to bring about from the ports.

The first is the way the two strobes of one access run against each other: either one can be the longer, and the 256-cycle weight of the top bit makes a few codes far longer than the rest. To cover this, the stimulus sweeps every one of the 128 codes through both the write strobe and the read chip-select field. It pairs each read code with a scrambled read-strobe code, so both orders of lengths occur, including the zero code and the codes that carry the 256 weight.

The second is a request or a register write that lands in the middle of a pulse. This only happens if the stimulus drives it while `busy` is high, so the bench issues a second start and a register rewrite a few cycles into a running pulse. It then measures that the pulse lengths and the single done are unchanged.

// File: rtl/spt_pkg.sv
package spt_pkg;

    localparam int REG_W        = 32;
    localparam int FIELD_STRIDE = 8;
    localparam int NUM_FIELDS   = 4;

    // Field slots inside a timing register; slot k starts at bit 8*k.
    localparam int F_WSTB = 0;
    localparam int F_CSWR = 1;
    localparam int F_RSTB = 2;
    localparam int F_CSRD = 3;

    typedef struct packed {
        logic is_wr;
        logic busy_prev;
    } ctl_t;

    function automatic logic [REG_W-1:0] impl_mask(input int code_w);
        logic [REG_W-1:0] m;
        m = '0;
        for (int f = 0; f < NUM_FIELDS; f++) begin
            for (int b = 0; b < code_w; b++) begin
                m[f*FIELD_STRIDE + b] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/spt_code_decode.sv
module spt_code_decode #(
    parameter int CODE_W    = 7,
    parameter int HI_WEIGHT = 256,
    parameter int LEN_W     = 9
) (
    input  logic [CODE_W-1:0] code,
    output logic [LEN_W-1:0]  len
);

    logic [LEN_W-1:0] raw;

    always_comb begin
        raw = (code[CODE_W-1] ? LEN_W'(HI_WEIGHT) : '0) + LEN_W'(code[CODE_W-2:0]);
        // A zero-length strobe is not allowed: stretch it to one cycle.
        len = (raw == '0) ? LEN_W'(1) : raw;
    end

endmodule

// File: rtl/spt_down_ctr.sv
module spt_down_ctr #(
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    output logic             active
);

    logic [LEN_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - LEN_W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/spt_regbank.sv
module spt_regbank
    import spt_pkg::*;
#(
    parameter int N_CS   = 4,
    parameter int ADDR_W = 8,
    parameter int CODE_W = 7
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          wr_en,
    input  logic [ADDR_W-1:0]                             addr,
    input  logic [REG_W-1:0]                              wdata,
    input  logic                                          wp_en,
    output logic [REG_W-1:0]                              rdata,
    output logic [N_CS-1:0][NUM_FIELDS-1:0][CODE_W-1:0]   fields
);

    localparam int WORD_W = ADDR_W - 2;
    localparam int CS_W   = $clog2(N_CS);
    localparam logic [WORD_W-1:0] FIRST_WORD = WORD_W'(1);
    localparam logic [WORD_W-1:0] LAST_WORD  = WORD_W'(N_CS);
    localparam logic [REG_W-1:0]  MASK       = impl_mask(CODE_W);

    logic [N_CS-1:0][NUM_FIELDS-1:0][CODE_W-1:0] fld_d, fld_q;
    logic [WORD_W-1:0] word;
    logic              hit;
    logic [CS_W-1:0]   idx;
    logic              unused_wbits;

    assign word         = addr[ADDR_W-1:2];
    assign hit          = (addr[1:0] == 2'b00) && (word >= FIRST_WORD) && (word <= LAST_WORD);
    assign idx          = CS_W'(word - FIRST_WORD);
    assign unused_wbits = ^(wdata & ~MASK);

    always_comb begin
        fld_d = fld_q;
        rdata = '0;
        if (wr_en && !wp_en && hit) begin
            for (int f = 0; f < NUM_FIELDS; f++) begin
                fld_d[idx][f] = wdata[f*FIELD_STRIDE +: CODE_W];
            end
        end
        if (hit) begin
            for (int f = 0; f < NUM_FIELDS; f++) begin
                rdata[f*FIELD_STRIDE +: CODE_W] = fld_q[idx][f];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < N_CS; n++) begin
                for (int f = 0; f < NUM_FIELDS; f++) begin
                    fld_q[n][f] <= CODE_W'(1);
                end
            end
        end else begin
            fld_q <= fld_d;
        end
    end

    assign fields = fld_q;

endmodule

// File: rtl/strobe_pulse_timer.sv
module strobe_pulse_timer
    import spt_pkg::*;
#(
    parameter int N_CS      = 4,
    parameter int ADDR_W    = 8,
    parameter int CODE_W    = 7,
    parameter int HI_WEIGHT = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr_en,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [31:0]             cfg_wdata,
    input  logic                    wp_en,
    output logic [31:0]             cfg_rdata,
    input  logic                    start,
    input  logic [$clog2(N_CS)-1:0] start_cs,
    input  logic                    start_wr,
    input  logic                    start_page,
    input  logic                    start_same_page,
    output logic                    cs_n,
    output logic                    rd_n,
    output logic                    wr_n,
    output logic                    busy,
    output logic                    done
);

    localparam int LEN_W = $clog2(HI_WEIGHT + 2**(CODE_W-1));

    logic [N_CS-1:0][NUM_FIELDS-1:0][CODE_W-1:0] fields;
    logic [NUM_FIELDS-1:0][LEN_W-1:0]            len;
    logic [LEN_W-1:0]                            cs_val, st_val;
    logic                                        accept, cs_act, st_act;
    ctl_t                                        ctl_d, ctl_q;

    spt_regbank #(
        .N_CS   (N_CS),
        .ADDR_W (ADDR_W),
        .CODE_W (CODE_W)
    ) u_regbank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr_en),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .wp_en  (wp_en),
        .rdata  (cfg_rdata),
        .fields (fields)
    );

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_dec
        spt_code_decode #(
            .CODE_W    (CODE_W),
            .HI_WEIGHT (HI_WEIGHT),
            .LEN_W     (LEN_W)
        ) u_dec (
            .code (fields[start_cs][g]),
            .len  (len[g])
        );
    end

    assign busy   = cs_act || st_act;
    assign accept = start && !busy;

    always_comb begin
        ctl_d = ctl_q;
        ctl_d.busy_prev = busy;
        if (accept) begin
            ctl_d.is_wr = start_wr;
        end
        if (start_wr) begin
            cs_val = len[F_CSWR];
            st_val = len[F_WSTB];
        end else if (start_page) begin
            cs_val = start_same_page ? len[F_RSTB] : len[F_CSRD];
            st_val = cs_val;
        end else begin
            cs_val = len[F_CSRD];
            st_val = len[F_RSTB];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    spt_down_ctr #(.LEN_W(LEN_W)) u_cs_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cs_val),
        .active   (cs_act)
    );

    spt_down_ctr #(.LEN_W(LEN_W)) u_st_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (st_val),
        .active   (st_act)
    );

    assign cs_n = !cs_act;
    assign rd_n = !(st_act && !ctl_q.is_wr);
    assign wr_n = !(st_act && ctl_q.is_wr);
    assign done = ctl_q.busy_prev && !busy;

endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
    parameter logic [31:0] UNUSED_MASK = 32'h8080_8080
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        cs_n,
    input logic        rd_n,
    input logic        wr_n,
    input logic [31:0] cfg_rdata
);

    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r7_strobe_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n || !rd_n || !wr_n) |-> busy);

    a_r8_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r5_one_data_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    a_r10_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & UNUSED_MASK) == 32'h0);

endmodule

bind strobe_pulse_timer spt_checker u_chk (.*);

// File: tb/strobe_pulse_timer_bench.sv
module strobe_pulse_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic        wp_en = 1'b0;
    logic [31:0] cfg_rdata;
    logic        start = 1'b0;
    logic [1:0]  start_cs = 2'd0;
    logic        start_wr = 1'b0;
    logic        start_page = 1'b0;
    logic        start_same_page = 1'b0;
    logic        cs_n, rd_n, wr_n, busy, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    strobe_pulse_timer u_strobe_pulse_timer (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_wr_en       (cfg_wr_en),
        .cfg_addr        (cfg_addr),
        .cfg_wdata       (cfg_wdata),
        .wp_en           (wp_en),
        .cfg_rdata       (cfg_rdata),
        .start           (start),
        .start_cs        (start_cs),
        .start_wr        (start_wr),
        .start_page      (start_page),
        .start_same_page (start_same_page),
        .cs_n            (cs_n),
        .rd_n            (rd_n),
        .wr_n            (wr_n),
        .busy            (busy),
        .done            (done)
    );

    function automatic int dec(input logic [6:0] c);
        int d;
        d = (c[6] ? 256 : 0) + int'(c[5:0]);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic logic [31:0] pack(input logic [6:0] csrd, rstb, cswr, wstb);
        return {1'b0, csrd, 1'b0, rstb, 1'b0, cswr, 1'b0, wstb};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic drive_start(input logic [1:0] cs, input bit wr, page, same);
        start_cs        = cs;
        start_wr        = wr;
        start_page      = page;
        start_same_page = same;
        start           = 1'b1;
    endtask

    // Pulse measurement: start is seen at edge E0; cycle c is the c-th negedge after E0.
    task automatic run_pulse(input logic [1:0] cs, input bit wr, page, same,
                             input int e_cs, input int e_st, input string req);
        int n_cs = 0, n_st = 0, n_other = 0, n_busy = 0, done_at = -1, mx;
        bit first_ok = 1'b0;
        mx = (e_cs > e_st) ? e_cs : e_st;
        @(negedge clk);
        drive_start(cs, wr, page, same);
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= 700; c++) begin
            if (!cs_n) n_cs++;
            if (wr ? !wr_n : !rd_n) n_st++;
            if (wr ? !rd_n : !wr_n) n_other++;
            if (busy) n_busy++;
            if (c == 1) first_ok = !cs_n && (wr ? !wr_n : !rd_n);
            if (done) begin
                done_at = c;
                break;
            end
            @(negedge clk);
        end
        check(n_cs == e_cs, {req, " cs_n low cycles"}, n_cs, e_cs);
        check(n_st == e_st, {req, " data strobe low cycles"}, n_st, e_st);
        check(n_other == 0, {req, " R5 other strobe low cycles"}, n_other, 0);
        check(first_ok, {req, " strobes low in first cycle"}, int'(first_ok), 1);
        check(done_at == mx + 1, {req, " R7 done cycle"}, done_at, mx + 1);
        check(n_busy == mx, {req, " R7 busy cycles"}, n_busy, mx);
        @(negedge clk);
        check(!done, {req, " R7 done one cycle"}, int'(done), 0);
    endtask

    initial begin : watchdog
        #2_000_000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        logic [6:0]  c2;
        int n_cs, n_wr, n_rd, done_cnt, done_at;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset values, R10: other addresses read zero
        check(busy == 1'b0 && cs_n && rd_n && wr_n && !done, "R7 idle after reset",
              int'(busy), 0);
        for (int n = 0; n < 4; n++) begin
            reg_read(8'(4 + 4*n), rd);
            check(rd == 32'h0101_0101, "R2 reset value", int'(rd), 32'h0101_0101);
        end
        reg_read(8'h00, rd);
        check(rd == 32'h0, "R10 address 0 reads zero", int'(rd), 0);

        // R10: unimplemented bits, R2 field placement
        reg_write(8'h08, 32'hFFFF_FFFF);
        reg_read(8'h08, rd);
        check(rd == 32'h7F7F_7F7F, "R10 unused bits read zero", int'(rd), 32'h7F7F_7F7F);
        reg_write(8'h00, 32'h1234_5678);
        reg_write(8'h14, 32'h1234_5678);
        reg_write(8'h0A, 32'h1234_5678);
        reg_read(8'h14, rd);
        check(rd == 32'h0, "R10 address 0x14 reads zero", int'(rd), 0);
        reg_read(8'h0A, rd);
        check(rd == 32'h0, "R10 misaligned address reads zero", int'(rd), 0);
        reg_read(8'h08, rd);
        check(rd == 32'h7F7F_7F7F, "R10 stray writes ignored", int'(rd), 32'h7F7F_7F7F);
        for (int n = 0; n < 4; n++) begin
            if (n != 1) begin
                reg_read(8'(4 + 4*n), rd);
                check(rd == 32'h0101_0101, "R10 neighbours untouched", int'(rd), 32'h0101_0101);
            end
        end

        // R3: write protect
        wp_en = 1'b1;
        reg_write(8'h0C, pack(7'd9, 7'd9, 7'd9, 7'd9));
        reg_read(8'h0C, rd);
        check(rd == 32'h0101_0101, "R3 protected write ignored", int'(rd), 32'h0101_0101);
        run_pulse(2'd2, 1'b1, 1'b0, 1'b0, 1, 1, "R3 protected lengths unchanged");
        wp_en = 1'b0;
        reg_write(8'h0C, pack(7'd9, 7'd9, 7'd9, 7'd9));
        reg_read(8'h0C, rd);
        check(rd == pack(7'd9, 7'd9, 7'd9, 7'd9), "R3 write after unprotect",
              int'(rd), int'(pack(7'd9, 7'd9, 7'd9, 7'd9)));

        // R1 + R5: every write-strobe code
        for (int c = 0; c < 128; c++) begin
            reg_write(8'h04, pack(7'd50, 7'd60, 7'd3, 7'(c)));
            run_pulse(2'd0, 1'b1, c[0], 1'b0, 3, dec(7'(c)), "R1 R5 write sweep");
        end

        // R1 + R4: every chip-select read code, paired with a scrambled read-strobe code
        for (int c = 0; c < 128; c++) begin
            c2 = 7'((c * 37 + 11) % 128);
            reg_write(8'h08, pack(7'(c), c2, 7'd40, 7'd41));
            run_pulse(2'd1, 1'b0, 1'b0, 1'b0, dec(7'(c)), dec(c2), "R1 R4 read sweep");
        end

        // R2: chip-select selection picks its own register
        reg_write(8'h04, pack(7'd2, 7'd3, 7'd4, 7'd5));
        reg_write(8'h08, pack(7'd6, 7'd7, 7'd8, 7'd9));
        reg_write(8'h0C, pack(7'd10, 7'd11, 7'd12, 7'd13));
        reg_write(8'h10, pack(7'd14, 7'd15, 7'd16, 7'd17));
        for (int n = 0; n < 4; n++) begin
            run_pulse(2'(n), 1'b0, 1'b0, 1'b0, 2 + 4*n, 3 + 4*n, "R2 select read");
            run_pulse(2'(n), 1'b1, 1'b0, 1'b0, 4 + 4*n, 5 + 4*n, "R2 select write");
        end

        // R6: page mode first and later accesses
        reg_write(8'h0C, pack(7'd5, 7'h42, 7'd7, 7'd8));
        run_pulse(2'd2, 1'b0, 1'b1, 1'b0, 5, 5, "R6 page first access");
        run_pulse(2'd2, 1'b0, 1'b1, 1'b1, 258, 258, "R6 page later access");
        run_pulse(2'd2, 1'b0, 1'b0, 1'b1, 5, 258, "R6 same-page without page mode");
        run_pulse(2'd2, 1'b1, 1'b1, 1'b1, 7, 8, "R5 page flags on write");

        // R8: start while busy ignored
        reg_write(8'h10, pack(7'd30, 7'd31, 7'd20, 7'd10));
        reg_write(8'h04, pack(7'h45, 7'h45, 7'h45, 7'h45));
        n_cs = 0; n_wr = 0; n_rd = 0; done_cnt = 0; done_at = -1;
        @(negedge clk);
        drive_start(2'd3, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= 60; c++) begin
            if (c == 5) drive_start(2'd0, 1'b0, 1'b0, 1'b0);
            if (c == 6) start = 1'b0;
            if (!cs_n) n_cs++;
            if (!wr_n) n_wr++;
            if (!rd_n) n_rd++;
            if (done) begin
                done_cnt++;
                if (done_at < 0) done_at = c;
            end
            @(negedge clk);
        end
        check(n_cs == 20, "R8 cs_n length kept", n_cs, 20);
        check(n_wr == 10, "R8 wr_n length kept", n_wr, 10);
        check(n_rd == 0, "R8 no read pulse from ignored start", n_rd, 0);
        check(done_cnt == 1, "R8 single done", done_cnt, 1);
        check(done_at == 21, "R8 done cycle", done_at, 21);

        // R9: register write during a pulse does not change it
        reg_write(8'h08, pack(7'd12, 7'd6, 7'd1, 7'd1));
        n_cs = 0; n_rd = 0;
        @(negedge clk);
        drive_start(2'd1, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= 40; c++) begin
            if (c == 3) begin
                cfg_wr_en = 1'b1;
                cfg_addr  = 8'h08;
                cfg_wdata = pack(7'd30, 7'd30, 7'd1, 7'd1);
            end
            if (c == 4) cfg_wr_en = 1'b0;
            if (!cs_n) n_cs++;
            if (!rd_n) n_rd++;
            @(negedge clk);
        end
        check(n_cs == 12, "R9 cs_n length from start edge", n_cs, 12);
        check(n_rd == 6, "R9 rd_n length from start edge", n_rd, 6);
        run_pulse(2'd1, 1'b0, 1'b0, 1'b0, 30, 30, "R9 new value on next access");

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule